// File: doc/BRIEF.md
# Stack Pointer Update Unit

This unit holds the stack pointer of a processor core. It changes the pointer for stack operations: push, pop, call and return. It also lets the pointer be loaded like an ordinary register. Each cycle the core presents an operation code and an operand-width flag. The unit gives back two things: the address the pending stack memory access must use, in the same cycle, and the updated pointer after the clock edge.

Stores pre-decrement and reads post-increment. A push or call lowers the pointer first and stores at the lowered value. A pop or return reads at the current value and raises the pointer afterwards. The step is 2 bytes for narrow (16-bit) operands and 4 bytes for wide (32-bit) operands. In narrow mode only the low half of the pointer moves. That half wraps at 2^16, and the upper half keeps its value. The memory access itself and any segment limit check belong to other blocks.

Top module: `stack_ptr_unit`

## Requirements
- R1: An active-low asynchronous reset `rstN` sets the pointer to `RESET_SP` (default 0).
- R2: Push (opCode 1) with `wide`=0 gives `accAddr` = zero-extended (low16(SP) - 2) in the same cycle. After the edge, the low 16 bits of SP equal that value and the upper 16 bits are unchanged.
- R3: Pop (opCode 2) with `wide`=0 gives `accAddr` = zero-extended low16(SP). After the edge, low16(SP) is raised by 2 and the upper 16 bits are unchanged.
- R4: With `wide`=1 the step is 4 and covers the full 32 bits. Push and call give `accAddr` = SP - 4, and SP becomes SP - 4. Pop and return give `accAddr` = SP, and SP becomes SP + 4.
- R5: Call (opCode 3) behaves exactly like push and return (opCode 4) behaves exactly like pop, in both widths.
- R6: General write (opCode 5) loads SP in one cycle. With `wide`=1 it loads all of `wrData`. With `wide`=0 it loads only `wrData[15:0]` into the low half and keeps the upper half. `accAddr` shows the current SP under the idle rule of R8.
- R7: Pointer arithmetic wraps modulo 2^16 in narrow mode, with no carry or borrow into the upper half, and modulo 2^32 in wide mode.
- R8: opCode 0 and the unused codes 6 and 7 leave SP unchanged. For these codes `accAddr` equals SP when `wide`=1 and zero-extended low16(SP) when `wide`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | 0 none, 1 push, 2 pop, 3 call, 4 return, 5 general write, 6-7 none |
| wide | input | 1 | 1 = 32-bit operand (step 4), 0 = 16-bit operand (step 2) |
| wrData | input | 32 | Value for general write |
| spOut | output | 32 | Current stack pointer |
| accAddr | output | 32 | Address for this cycle's stack access |

## Verification
The pointer register is the unit's only state, and `spOut` shows it directly. A wrong value is therefore visible at the port one edge after the faulty update. The same wrong value also distorts the `accAddr` that the next operation computes combinationally. A borrow leaking into the upper half in narrow mode only shows when the low half crosses zero, and a wrong step size only shows in one width. For that reason the sweep combines every operation code and both widths with start values that sit on either side of the wrap points.

// File: rtl/stack_ptr_pkg.sv
`timescale 1ns/1ps
package stack_ptr_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_WRITE = 3'd5
  } spOp_e;

  typedef struct packed {
    logic dec;
    logic inc;
    logic load;
    logic wide;
  } spStrobe_t;

endpackage

// File: rtl/stack_ptr_ctrl.sv
`timescale 1ns/1ps
module stack_ptr_ctrl
  import stack_ptr_pkg::*;
(
  input  logic [2:0] opCode,
  input  logic       wide,
  output spStrobe_t  strobes
);

  always_comb begin
    strobes      = '0;
    strobes.wide = wide;
    unique case (opCode)
      OP_PUSH, OP_CALL: strobes.dec  = 1'b1;
      OP_POP,  OP_RET:  strobes.inc  = 1'b1;
      OP_WRITE:         strobes.load = 1'b1;
      default:          ;
    endcase
  end

endmodule

// File: rtl/stack_ptr_datapath.sv
`timescale 1ns/1ps
module stack_ptr_datapath
  import stack_ptr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter logic [DATA_W-1:0] RESET_SP = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobe_t         strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] accAddr
);

  localparam int HI_W   = DATA_W - NARROW_W;
  localparam int NSTEP  = NARROW_W / 8;
  localparam int WSTEP  = DATA_W / 8;

  logic [DATA_W-1:0]   spQ, spD;
  logic [DATA_W-1:0]   wideDec, wideInc;
  logic [NARROW_W-1:0] narDec, narInc;
  logic [HI_W-1:0]     upperKeep;

  assign upperKeep = spQ[DATA_W-1:NARROW_W];
  assign wideDec   = spQ - DATA_W'(WSTEP);
  assign wideInc   = spQ + DATA_W'(WSTEP);
  assign narDec    = spQ[NARROW_W-1:0] - NARROW_W'(NSTEP);
  assign narInc    = spQ[NARROW_W-1:0] + NARROW_W'(NSTEP);

  always_comb begin
    if (strobes.load)
      spD = strobes.wide ? wrData : {upperKeep, wrData[NARROW_W-1:0]};
    else if (strobes.dec)
      spD = strobes.wide ? wideDec : {upperKeep, narDec};
    else if (strobes.inc)
      spD = strobes.wide ? wideInc : {upperKeep, narInc};
    else
      spD = spQ;
  end

  always_comb begin
    if (strobes.dec)
      accAddr = strobes.wide ? wideDec : {HI_W'(0), narDec};
    else
      accAddr = strobes.wide ? spQ : {HI_W'(0), spQ[NARROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) spQ <= RESET_SP;
    else       spQ <= spD;
  end

  assign spOut = spQ;

endmodule

// File: rtl/stack_ptr_unit.sv
`timescale 1ns/1ps
module stack_ptr_unit
  import stack_ptr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter logic [DATA_W-1:0] RESET_SP = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic              wide,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] accAddr
);

  spStrobe_t strobes;

  stack_ptr_ctrl ctrl_i (
    .opCode (opCode),
    .wide   (wide),
    .strobes(strobes)
  );

  stack_ptr_datapath #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .RESET_SP(RESET_SP)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .spOut  (spOut),
    .accAddr(accAddr)
  );

endmodule

// File: rtl/stack_ptr_unit_chk.sv
`timescale 1ns/1ps
module stack_ptr_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opCode,
  input logic              wide,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] spOut,
  input logic [DATA_W-1:0] accAddr
);

  localparam int NW = NARROW_W;
  localparam int HW = DATA_W - NARROW_W;

  logic isDec, isInc;
  assign isDec = (opCode == 3'd1) || (opCode == 3'd3);
  assign isInc = (opCode == 3'd2) || (opCode == 3'd4);

  // R2 / R5: narrow store address is the lowered low half
  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isDec && !wide) |-> accAddr == {HW'(0), NW'(spOut[NW-1:0] - NW'(NARROW_W/8))});

  // R2 / R7: narrow decrement leaves upper half alone
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isDec && !wide) |=> (spOut[NW-1:0] == NW'($past(spOut[NW-1:0]) - NW'(NARROW_W/8)))
                         && $stable(spOut[DATA_W-1:NW]));

  // R3: narrow pop reads at current pointer then raises it
  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isInc && !wide) |=> (spOut[NW-1:0] == NW'($past(spOut[NW-1:0]) + NW'(NARROW_W/8)))
                         && $stable(spOut[DATA_W-1:NW]));

  // R4: wide step of four
  p_wide_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isDec && wide) |=> spOut == $past(spOut) - DATA_W'(DATA_W/8));

  p_wide_inc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isInc && wide) |-> accAddr == spOut);

  // R6: wide general write
  p_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd5 && wide) |=> spOut == $past(wrData));

  // R8: idle codes hold the pointer
  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd0 || opCode == 3'd6 || opCode == 3'd7) |=> $stable(spOut));

endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W)
) chk_i (.*);

// File: tb/stack_ptr_unit_tb.sv
`timescale 1ns/1ps
module stack_ptr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic        wide = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] spOut, accAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] refSp = '0;

  always #10 clk = ~clk;

  stack_ptr_unit dut_i (
    .clk(clk), .rstN(rstN), .opCode(opCode), .wide(wide),
    .wrData(wrData), .spOut(spOut), .accAddr(accAddr)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(logic [2:0] op, logic w, logic [31:0] sp);
    logic dec;
    dec = (op == 3'd1) || (op == 3'd3);
    if (w) return dec ? sp - 32'd4 : sp;
    return dec ? {16'h0, sp[15:0] - 16'd2} : {16'h0, sp[15:0]};
  endfunction

  function automatic logic [31:0] expNext(logic [2:0] op, logic w, logic [31:0] sp, logic [31:0] d);
    case (op)
      3'd1, 3'd3: return w ? sp - 32'd4 : {sp[31:16], sp[15:0] - 16'd2};
      3'd2, 3'd4: return w ? sp + 32'd4 : {sp[31:16], sp[15:0] + 16'd2};
      3'd5:       return w ? d : {sp[31:16], d[15:0]};
      default:    return sp;
    endcase
  endfunction

  // called just after a falling edge
  task automatic doOp(logic [2:0] op, logic w, logic [31:0] d, string tag);
    opCode = op; wide = w; wrData = d;
    #5;
    check(tag, "accAddr", accAddr, expAddr(op, w, refSp));
    @(negedge clk);
    refSp = expNext(op, w, refSp, d);
    check(tag, "spOut", spOut, refSp);
  endtask

  function automatic string tagFor(logic [2:0] op, logic w);
    if (op == 3'd5) return "R6";
    if (op == 3'd0 || op > 3'd5) return "R8";
    if (w) return "R4";
    if (op == 3'd3 || op == 3'd4) return "R5";
    return (op == 3'd1) ? "R2" : "R3";
  endfunction

  initial begin
    logic [31:0] starts [6];
    starts = '{32'h0000_0000, 32'h0000_0002, 32'hABCD_FFFE,
               32'h1234_0001, 32'hFFFF_FFFC, 32'h8000_0003};
    @(negedge clk);
    check("R1", "spOut in reset", spOut, 32'h0);
    check("R1", "accAddr in reset", accAddr, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    refSp = '0;
    check("R1", "spOut after reset", spOut, 32'h0);

    foreach (starts[i]) begin
      for (int w = 0; w < 2; w++) begin
        for (int op = 0; op < 8; op++) begin
          doOp(3'd5, 1'b1, starts[i], "R6");
          doOp(3'(op), 1'(w), starts[i] ^ 32'h5A5A_C3C3, tagFor(3'(op), 1'(w)));
        end
      end
    end

    // R7 wrap corners
    doOp(3'd5, 1'b1, 32'hABCD_0000, "R6");
    doOp(3'd1, 1'b0, '0, "R7");
    check("R7", "narrow borrow kept out of upper half", spOut, 32'hABCD_FFFE);
    doOp(3'd2, 1'b0, '0, "R7");
    doOp(3'd2, 1'b0, '0, "R7");
    doOp(3'd5, 1'b1, 32'h0000_0000, "R6");
    doOp(3'd3, 1'b1, '0, "R7");
    check("R7", "wide wrap down", spOut, 32'hFFFF_FFFC);
    doOp(3'd4, 1'b1, '0, "R7");
    doOp(3'd5, 1'b1, 32'h7777_FFFF, "R6");
    doOp(3'd2, 1'b0, '0, "R7");
    check("R7", "narrow carry kept out of upper half", spOut, 32'h7777_0001);

    // R6 narrow write keeps upper half, then back-to-back stack chain
    doOp(3'd5, 1'b0, 32'h1111_2222, "R6");
    check("R6", "narrow write", spOut, 32'h7777_2222);
    for (int k = 0; k < 4; k++) doOp(3'd1, 1'b0, '0, "R2");
    for (int k = 0; k < 4; k++) doOp(3'd4, 1'b0, '0, "R5");
    check("R5", "balanced chain", spOut, 32'h7777_2222);

    // R1 reset mid-run
    rstN = 1'b0;
    #5;
    check("R1", "async reset", spOut, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule